// File: doc/BRIEF.md
# Zero-Page Single-Bit Execution Unit

This unit executes the single-bit instructions of a small 8-bit processor. It supports four operation families, each with eight bit positions, for 32 opcodes in all. Two families force one bit of a zero-page byte to 0 or to 1. The other two test one bit of a zero-page byte and take a relative branch when the bit is 0, or when it is 1. The bit index is part of the opcode. The unit owns the 16-bit program counter and fetches its instruction bytes itself over a byte-wide read port with one cycle of latency. It reaches the data byte over a separate synchronous memory port, which also has one cycle of read latency.

A pulse on `start` while the unit is idle begins one instruction at the current program counter. The state machine moves through these states:

- IDLE goes to OPCODE on `start`.
- OPCODE goes to DECODE unconditionally. The opcode fetch is issued in OPCODE.
- DECODE goes to ZPADDR for a legal opcode, or back to IDLE for an illegal one. The opcode arrives and is decoded in DECODE.
- ZPADDR goes to WRITE for a bit-modify opcode, or to BRANCH for a bit-test opcode. The zero-page address arrives in ZPADDR and the data read is issued there.
- WRITE goes to IDLE. The byte is written back in WRITE.
- BRANCH goes to IDLE. The displacement is applied in BRANCH.

No processor status flag is touched by any of the four families.

Top module: `zpbit_unit`

## Requirements
- R1: After reset the program counter equals the RESET_PC parameter and `busy`, `done`, `illegal`, `fetch_rd`, `mem_rd` and `mem_wr` are all low.
- R2: The cycle after `start` is sampled in IDLE, `fetch_rd` is high with `fetch_addr` equal to the program counter. For a legal opcode, the following cycle fetches the address one above it.
- R3: An opcode whose low nibble is neither 4'h7 nor 4'hF is illegal. In the cycle its byte arrives, `done` and `illegal` rise together, no memory access is made, and the program counter keeps its value.
- R4: In the cycle after the address byte is fetched, `mem_rd` is high and `mem_addr` is that byte with all upper address bits zero.
- R5: Opcode {0,n,4'h7} writes back, one cycle after the read, the byte read with bit n cleared and the other seven bits unchanged, to the same address. The program counter then advances by 2.
- R6: Opcode {1,n,4'h7} does the same as R5, except that bit n is set.
- R7: Opcode {0,n,4'hF} fetches a third byte, the displacement, at the program counter plus 2, and makes no memory write. When bit n of the tested byte is 0, the program counter becomes PC+3 plus the sign-extended displacement. Otherwise it becomes PC+3.
- R8: Opcode {1,n,4'hF} behaves as R7, but the branch is taken when bit n is 1.
- R9: All program-counter arithmetic, including operand fetch addresses and branch targets, wraps modulo 65536. This applies both forward and backward.
- R10: `busy` stays high from the cycle after `start` through the cycle in which `done` pulses. `done` lasts exactly one cycle: in DECODE for an illegal opcode, in WRITE or BRANCH otherwise.
- R11: `start` has no effect while `busy` is high. The unit returns to idle after one instruction, with the program counter updated once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one instruction at the program counter |
| fetch_rd | output | 1 | Instruction byte read strobe |
| fetch_addr | output | 16 | Instruction byte address |
| fetch_data | input | 8 | Instruction byte, valid the cycle after `fetch_rd` |
| mem_rd | output | 1 | Data read strobe |
| mem_wr | output | 1 | Data write strobe |
| mem_addr | output | 16 | Data address, always in page zero |
| mem_wdata | output | 8 | Data byte written |
| mem_rdata | input | 8 | Data byte, valid the cycle after `mem_rd` |
| pc | output | 16 | Program counter |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Opcode not handled; valid with `done` |

## Verification
Counting from the clock edge that samples `start`, the results fall due as follows:

- The opcode fetch appears one cycle later.
- An illegal opcode completes two cycles later.
- The data read appears three cycles later.
- The write-back or branch decision comes four cycles later.
- The new program counter is visible after the fifth edge.

The bench drives its stimulus on falling edges, steps its model one instruction phase per clock, and compares every strobe, address and data output at each falling edge against that phase. Byte arrival, write landing and the final program counter are each checked in the exact cycle named above.

// File: rtl/zpbit_pkg.sv
package zpbit_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);

    localparam logic [3:0] NIB_MODIFY = 4'h7;
    localparam logic [3:0] NIB_TEST   = 4'hF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_DECODE,
        ST_ZPADDR,
        ST_WRITE,
        ST_BRANCH
    } zpb_state_e;

    typedef struct packed {
        logic              legal;
        logic              is_test;
        logic              polarity;
        logic [IDX_W-1:0]  idx;
    } zpb_dec_t;

endpackage

// File: rtl/zpbit_decode.sv
module zpbit_decode
    import zpbit_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output zpb_dec_t          dec
);
    logic [3:0] low_nib;

    assign low_nib = opcode[3:0];

    always_comb begin
        dec.legal    = (low_nib == NIB_MODIFY) || (low_nib == NIB_TEST);
        dec.is_test  = (low_nib == NIB_TEST);
        dec.polarity = opcode[BYTE_W-1];
        dec.idx      = opcode[BYTE_W-2 -: IDX_W];
    end
endmodule

// File: rtl/zpbit_bitop.sv
module zpbit_bitop
    import zpbit_pkg::*;
(
    input  logic [BYTE_W-1:0] rdata,
    input  logic [IDX_W-1:0]  idx,
    input  logic              polarity,
    output logic [BYTE_W-1:0] wdata,
    output logic              bit_val
);
    for (genvar g = 0; g < BYTE_W; g++) begin : g_lane
        assign wdata[g] = (idx == IDX_W'(g)) ? polarity : rdata[g];
    end

    assign bit_val = rdata[idx];
endmodule

// File: rtl/zpbit_target.sv
module zpbit_target
    import zpbit_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [BYTE_W-1:0] disp,
    input  logic              taken,
    output logic [ADDR_W-1:0] next_pc
);
    localparam int EXT_W = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] offset;

    assign seq_pc  = pc + ADDR_W'(3);
    assign offset  = {{EXT_W{disp[BYTE_W-1]}}, disp};
    assign next_pc = taken ? (seq_pc + offset) : seq_pc;
endmodule

// File: rtl/zpbit_unit.sv
module zpbit_unit
    import zpbit_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = 16'h0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              fetch_rd,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic [BYTE_W-1:0] fetch_data,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc,
    output logic              busy,
    output logic              done,
    output logic              illegal
);
    localparam int HI_W = ADDR_W - BYTE_W;

    zpb_state_e        state_q, state_d;
    zpb_dec_t          dec_now, dec_q;
    logic [BYTE_W-1:0] zp_q;
    logic [ADDR_W-1:0] pc_q, pc_d;
    logic [ADDR_W-1:0] br_target;
    logic [BYTE_W-1:0] mod_byte;
    logic              sel_bit;
    logic              taken;

    zpbit_decode u_decode (
        .opcode (fetch_data),
        .dec    (dec_now)
    );

    zpbit_bitop u_bitop (
        .rdata    (mem_rdata),
        .idx      (dec_q.idx),
        .polarity (dec_q.polarity),
        .wdata    (mod_byte),
        .bit_val  (sel_bit)
    );

    assign taken = (sel_bit == dec_q.polarity);

    zpbit_target #(.ADDR_W(ADDR_W)) u_target (
        .pc      (pc_q),
        .disp    (fetch_data),
        .taken   (taken),
        .next_pc (br_target)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_OPCODE;
            ST_OPCODE: state_d = ST_DECODE;
            ST_DECODE: state_d = dec_now.legal ? ST_ZPADDR : ST_IDLE;
            ST_ZPADDR: state_d = dec_q.is_test ? ST_BRANCH : ST_WRITE;
            ST_WRITE:  state_d = ST_IDLE;
            ST_BRANCH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        fetch_rd   = 1'b0;
        fetch_addr = pc_q;
        mem_rd     = 1'b0;
        mem_wr     = 1'b0;
        mem_addr   = {{HI_W{1'b0}}, zp_q};
        mem_wdata  = mod_byte;
        busy       = 1'b1;
        done       = 1'b0;
        illegal    = 1'b0;
        pc_d       = pc_q;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_OPCODE: begin
                fetch_rd   = 1'b1;
                fetch_addr = pc_q;
            end
            ST_DECODE: begin
                if (dec_now.legal) begin
                    fetch_rd   = 1'b1;
                    fetch_addr = pc_q + ADDR_W'(1);
                end else begin
                    done    = 1'b1;
                    illegal = 1'b1;
                end
            end
            ST_ZPADDR: begin
                mem_rd   = 1'b1;
                mem_addr = {{HI_W{1'b0}}, fetch_data};
                if (dec_q.is_test) begin
                    fetch_rd   = 1'b1;
                    fetch_addr = pc_q + ADDR_W'(2);
                end
            end
            ST_WRITE: begin
                mem_wr = 1'b1;
                done   = 1'b1;
                pc_d   = pc_q + ADDR_W'(2);
            end
            ST_BRANCH: begin
                done = 1'b1;
                pc_d = br_target;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= RESET_PC;
            dec_q <= '0;
            zp_q  <= '0;
        end else begin
            pc_q <= pc_d;
            if (state_q == ST_DECODE) dec_q <= dec_now;
            if (state_q == ST_ZPADDR) zp_q  <= fetch_data;
        end
    end

    assign pc = pc_q;
endmodule

// File: rtl/zpbit_sva.sv
module zpbit_sva
    import zpbit_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              fetch_rd,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [BYTE_W-1:0] mem_wdata,
    input logic [BYTE_W-1:0] mem_rdata,
    input logic [ADDR_W-1:0] pc,
    input logic              busy,
    input logic              done,
    input logic              illegal
);
    localparam int HI_W = ADDR_W - BYTE_W;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fetch_rd && !mem_rd && !mem_wr && !done));

    p_busy_needs_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_illegal_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !mem_rd && !mem_wr));

    p_page_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (mem_addr[ADDR_W-1 -: HI_W] == '0));

    p_write_follows_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(mem_rd) && mem_addr == $past(mem_addr)));

    p_single_bit_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($countones(mem_wdata ^ mem_rdata) <= 1));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_pc_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(pc));

    p_rd_wr_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
endmodule

bind zpbit_unit zpbit_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .fetch_rd  (fetch_rd),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .pc        (pc),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal)
);

// File: tb/zpbit_unit_bench.sv
module zpbit_unit_bench;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        fetch_rd, mem_rd, mem_wr, busy, done, illegal;
    logic [15:0] fetch_addr, mem_addr, pc;
    logic [7:0]  fetch_data = 8'h00;
    logic [7:0]  mem_rdata  = 8'h00;
    logic [7:0]  mem_wdata;

    zpbit_unit #(.ADDR_W(16), .RESET_PC(16'hFFF0)) u_zpbit_unit (
        .clk(clk), .rst_n(rst_n), .start(start),
        .fetch_rd(fetch_rd), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pc(pc), .busy(busy), .done(done), .illegal(illegal)
    );

    // Memory models
    logic [7:0]  zmem [0:255];
    logic [7:0]  ib   [0:2];
    logic [15:0] ib_base = 16'h0000;
    logic [15:0] ib_off;
    logic        pre_en = 1'b0;
    logic [7:0]  pre_addr = 8'h00, pre_data = 8'h00;

    assign ib_off = fetch_addr - ib_base;

    always @(posedge clk) begin
        if (fetch_rd) fetch_data <= (ib_off < 16'd3) ? ib[ib_off[1:0]] : 8'hEA;
        if (mem_rd)   mem_rdata  <= zmem[mem_addr[7:0]];
        if (mem_wr)   zmem[mem_addr[7:0]] <= mem_wdata;
        else if (pre_en) zmem[pre_addr] <= pre_data;
    end

    int total = 0;
    int bad   = 0;
    logic [15:0] pc_m;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [7:0] op, input logic [7:0] zp, input logic [7:0] disp,
                       input logic [7:0] init, input bit hold, input string pc_tag);
        bit          legal, tst, pol, bitv, tk;
        int          idx;
        logic [7:0]  exp_w;
        logic [15:0] exp_pc;
        legal = (op[3:0] == 4'h7) || (op[3:0] == 4'hF);
        tst   = (op[3:0] == 4'hF);
        pol   = op[7];
        idx   = int'(op[6:4]);
        bitv  = init[idx];
        tk    = (bitv == pol);
        exp_w = init;
        exp_w[idx] = pol;
        if (tst) exp_pc = tk ? (pc_m + 16'd3 + {{8{disp[7]}}, disp}) : (pc_m + 16'd3);
        else     exp_pc = pc_m + 16'd2;

        ib_base = pc_m; ib[0] = op; ib[1] = zp; ib[2] = disp;
        pre_en = 1'b1; pre_addr = zp; pre_data = init;
        @(negedge clk);
        pre_en = 1'b0;
        start  = 1'b1;
        @(negedge clk);                       // OPCODE
        if (!hold) start = 1'b0;
        chk("R10 busy", busy, 1);
        chk("R2 fetch_rd", fetch_rd, 1);
        chk("R2 fetch_addr", fetch_addr, pc_m);
        chk("R10 done", done, 0);
        chk("R4 mem_rd early", mem_rd, 0);
        @(negedge clk);                       // DECODE
        if (!legal) begin
            start = 1'b0;
            chk("R3 done", done, 1);
            chk("R3 illegal", illegal, 1);
            chk("R3 mem_rd", mem_rd, 0);
            chk("R3 mem_wr", mem_wr, 0);
            @(negedge clk);
            chk("R3 pc kept", pc, pc_m);
            chk("R10 busy low", busy, 0);
            chk("R10 done once", done, 0);
            return;
        end
        chk("R10 done", done, 0);
        chk("R2 fetch_rd 2", fetch_rd, 1);
        chk("R9 fetch_addr+1", fetch_addr, pc_m + 16'd1);
        @(negedge clk);                       // ZPADDR
        chk("R4 mem_rd", mem_rd, 1);
        chk("R4 mem_addr", mem_addr, {8'h00, zp});
        chk("R7 no write", mem_wr, 0);
        chk("R7 disp fetch", fetch_rd, tst);
        if (tst) chk("R9 fetch_addr+2", fetch_addr, pc_m + 16'd2);
        start = 1'b0;
        @(negedge clk);                       // WRITE or BRANCH
        chk("R10 done", done, 1);
        chk("R3 illegal low", illegal, 0);
        chk("R11 busy", busy, 1);
        if (tst) begin
            chk(pol ? "R8 no write" : "R7 no write", mem_wr, 0);
        end else begin
            chk(pol ? "R6 mem_wr" : "R5 mem_wr", mem_wr, 1);
            chk(pol ? "R6 mem_addr" : "R5 mem_addr", mem_addr, {8'h00, zp});
            chk(pol ? "R6 mem_wdata" : "R5 mem_wdata", mem_wdata, exp_w);
        end
        @(negedge clk);                       // back to IDLE
        chk(pc_tag, pc, exp_pc);
        chk("R11 busy low", busy, 0);
        chk("R10 done once", done, 0);
        chk("R11 no refetch", fetch_rd, 0);
        chk(tst ? "R7 byte kept" : "R5 byte stored", zmem[zp], tst ? init : exp_w);
        pc_m = exp_pc;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) zmem[i] = 8'h00;
        ib[0] = 8'h00; ib[1] = 8'h00; ib[2] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pc", pc, 16'hFFF0);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 illegal", illegal, 0);
        chk("R1 fetch_rd", fetch_rd, 0);
        chk("R1 mem_rd", mem_rd, 0);
        chk("R1 mem_wr", mem_wr, 0);
        pc_m = 16'hFFF0;

        run(8'h37, 8'h40, 8'h00, 8'hFF, 0, "R5 pc");   // clear bit 3
        run(8'h87, 8'h41, 8'h00, 8'h00, 0, "R6 pc");   // set bit 0
        run(8'h5F, 8'h42, 8'h10, 8'h20, 0, "R7 pc");   // test-clear bit 5, not taken
        run(8'hFF, 8'h43, 8'h10, 8'h80, 0, "R9 pc");   // test-set bit 7, taken, wraps forward
        run(8'hA9, 8'h44, 8'h00, 8'h00, 0, "R3 pc");   // illegal
        run(8'h2F, 8'h45, 8'hF0, 8'hFB, 1, "R9 pc");   // test-clear bit 2, taken, wraps back
        run(8'h9F, 8'h46, 8'h40, 8'hFD, 0, "R8 pc");   // test-set bit 1, not taken
        run(8'hF7, 8'h47, 8'h00, 8'h80, 0, "R6 pc");   // set bit 7 already set
        run(8'h67, 8'h48, 8'h00, 8'h40, 1, "R5 pc");   // clear bit 6, start held
        run(8'hCF, 8'h49, 8'h80, 8'h10, 0, "R8 pc");   // test-set bit 4, taken, disp -128
        run(8'h00, 8'h4A, 8'h00, 8'h00, 0, "R3 pc");   // illegal
        chk("R9 final pc", pc, 16'hFF87);

        repeat (3) @(negedge clk);
        chk("R11 stays idle", busy, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule